// File: doc/BRIEF.md
# Stretched External Reset Generator

This block converts an asynchronous, active-high reset request arriving on a chip pin into an internal reset pulse of fixed length. The pin first crosses into the clock domain through a short synchronizer chain. It is then examined only on a slow sampling tick that is derived from the selectable peripheral clock. The request counts only if the pin is high at one tick and stays high through the whole following tick period. The internal reset then rises and is held for a fixed number of tick periods. It is released after that span even if the pin is still high. Before another request can be accepted, the pin must be seen low at a tick, so a pin that is stuck high cannot retrigger the reset over and over.

A power-on hold input stands in for the analog power-on detector. While it is high it forces the internal reset high and returns the controller to its idle state. The busy output shows when the stretched pulse is running. Both the qualification time and the pulse length are counted in ticks, so they scale with the peripheral clock choice that paces the tick.

The controller has four states. `ST_IDLE` waits for a tick with the pin high. `ST_ARMED` means the pin was high at the last tick. `ST_PULSE` drives the stretched reset. `ST_RELOCK` waits for the pin to be released.

The transitions are:
- idle to armed (arm): a tick with the pin high.
- armed to pulse (qualify): the next tick, with the pin still high.
- armed to idle (cancel): the pin is seen low at any cycle.
- pulse to relock (expire): the last counted tick.
- relock to idle (release): a tick with the pin low.
- any state to idle (power-on): while the hold input is high.

Top module: `ext_rst_stretch`

## Requirements
- R1: While `pwr_on_hold` is high, `int_rst` is 1 and `busy` is 0, and the controller returns to idle.
- R2: From idle, the reset is accepted only when the synchronized pin is high at one tick and is still high at the next tick. `int_rst` and `busy` become 1 in the cycle after that second tick.
- R3: If the pin falls low before the qualifying second tick, no reset is produced.
- R4: Once asserted, the stretched reset lasts exactly PULSE_TICKS tick periods. It deasserts at the PULSE_TICKS-th tick after assertion, whatever the level of the pin.
- R5: After a stretched reset ends, no new reset starts until the pin has been sampled low at a tick. A pin held high keeps `int_rst` at 0.
- R6: `busy` is 1 exactly while the stretched pulse runs, and `busy` implies `int_rst`.
- R7: The pin passes through SYNC_STAGES (default 2) flops. A rise driven in the same cycle as a tick is not seen at that tick.
- R8: In idle, pin activity between ticks that has ended before the next tick has no effect.
- R9: Raising `pwr_on_hold` during a stretched pulse aborts the pulse. After the hold is released, the controller is idle and needs a new two-tick qualification.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pwr_on_hold | input | 1 | Power-on hold, active high, asynchronous assertion |
| sample_tick | input | 1 | One-cycle slow sampling strobe derived from the peripheral clock |
| ext_rst_pin | input | 1 | Raw external reset request, active high, asynchronous |
| int_rst | output | 1 | Internal reset, active high |
| busy | output | 1 | High while the fixed-length pulse runs |

## Verification
The bench builds the block with PULSE_TICKS at its default of ten and two synchronizer stages. It paces the tick every eight clocks, so the full ten-tick span can be walked tick by tick. The long release window with the pin held high and the one with the pin low both come within reach in a few hundred cycles. The eight-cycle tick spacing also leaves room to place a pin edge exactly one cycle before a tick, or a short burst wholly between two ticks. This exposes the synchronizer latency and the tick-only sampling at the ports.

// File: rtl/ers_pkg.sv
package ers_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_PULSE  = 2'd2,
        ST_RELOCK = 2'd3
    } ers_state_t;
endpackage

// File: rtl/ers_sync.sv
module ers_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or posedge arst) begin
                    if (arst) chain[0] <= 1'b0;
                    else      chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or posedge arst) begin
                    if (arst) chain[i] <= 1'b0;
                    else      chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/ers_len_cnt.sv
module ers_len_cnt #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic arst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or posedge arst) begin
        if (arst)         cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (tick)    cnt <= cnt + 1'b1;
    end

    assign done = run && tick && (cnt == LAST);
endmodule

// File: rtl/ext_rst_stretch.sv
module ext_rst_stretch #(
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_TICKS = 10
) (
    input  logic clk,
    input  logic pwr_on_hold,
    input  logic sample_tick,
    input  logic ext_rst_pin,
    output logic int_rst,
    output logic busy
);
    import ers_pkg::*;

    ers_state_t state, state_nx;
    logic       pin_s;
    logic       span_done;
    logic       in_pulse;

    ers_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .arst    (pwr_on_hold),
        .d_async (ext_rst_pin),
        .q_sync  (pin_s)
    );

    assign in_pulse = (state == ST_PULSE);

    ers_len_cnt #(.LIMIT(PULSE_TICKS)) u_len (
        .clk  (clk),
        .arst (pwr_on_hold),
        .run  (in_pulse),
        .tick (sample_tick),
        .done (span_done)
    );

    // state register
    always_ff @(posedge clk or posedge pwr_on_hold) begin
        if (pwr_on_hold) state <= ST_IDLE;
        else             state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (sample_tick && pin_s)  state_nx = ST_ARMED;
            ST_ARMED:  if (!pin_s)                state_nx = ST_IDLE;
                       else if (sample_tick)      state_nx = ST_PULSE;
            ST_PULSE:  if (span_done)             state_nx = ST_RELOCK;
            ST_RELOCK: if (sample_tick && !pin_s) state_nx = ST_IDLE;
            default:                              state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = in_pulse;
        int_rst = pwr_on_hold | in_pulse;
    end
endmodule

// File: rtl/ers_chk.sv
module ers_chk #(
    parameter int PULSE_TICKS = 10
) (
    input logic clk,
    input logic pwr_on_hold,
    input logic sample_tick,
    input logic int_rst,
    input logic busy
);
    localparam int CW = $clog2(PULSE_TICKS + 1);

    logic [CW-1:0] seen_ticks;

    always_ff @(posedge clk) begin
        if (pwr_on_hold || !busy) seen_ticks <= '0;
        else if (sample_tick)     seen_ticks <= seen_ticks + 1'b1;
    end

    // R1
    hold_forces_rst_chk: assert property (@(posedge clk)
        pwr_on_hold |-> (int_rst && !busy));

    // R6
    busy_implies_rst_chk: assert property (@(posedge clk) disable iff (pwr_on_hold)
        busy |-> int_rst);

    // R2
    start_on_tick_chk: assert property (@(posedge clk) disable iff (pwr_on_hold)
        $rose(busy) |-> $past(sample_tick));

    // R4
    span_bound_chk: assert property (@(posedge clk) disable iff (pwr_on_hold)
        busy |-> (seen_ticks < CW'(PULSE_TICKS)));

    // R4
    span_end_chk: assert property (@(posedge clk) disable iff (pwr_on_hold)
        $fell(busy) |-> ($past(sample_tick) && ($past(seen_ticks) == CW'(PULSE_TICKS - 1))));
endmodule

bind ext_rst_stretch ers_chk #(.PULSE_TICKS(PULSE_TICKS)) u_chk (
    .clk         (clk),
    .pwr_on_hold (pwr_on_hold),
    .sample_tick (sample_tick),
    .int_rst     (int_rst),
    .busy        (busy)
);

// File: tb/ext_rst_stretch_tb.sv
module ext_rst_stretch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 8;
    localparam int NROWS      = 33;

    // each row: {pin level for the period, expected int_rst, expected busy} after the tick
    localparam logic [2:0] VEC [NROWS] = '{
        3'b100, // R2 arm
        3'b000, // R3 cancel
        3'b100,
        3'b111, // R2 qualified
        3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111, 3'b111,
        3'b100, // R4 release with pin high
        3'b100, // R5 held pin does not retrigger
        3'b100,
        3'b000, // R5 pin seen low
        3'b100,
        3'b000, // R3 cancel again
        3'b100,
        3'b111,
        3'b011, 3'b011, 3'b011, 3'b011, 3'b011, 3'b011, 3'b011, 3'b011, 3'b011, // R4 pin low
        3'b000,
        3'b000,
        3'b100
    };

    logic clk = 1'b0;
    logic pwr_on_hold = 1'b1;
    logic sample_tick = 1'b0;
    logic ext_rst_pin = 1'b0;
    logic int_rst;
    logic busy;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_rst_stretch u_dut (
        .clk         (clk),
        .pwr_on_hold (pwr_on_hold),
        .sample_tick (sample_tick),
        .ext_rst_pin (ext_rst_pin),
        .int_rst     (int_rst),
        .busy        (busy)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic fire_tick();
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic period(input logic pin);
        ext_rst_pin = pin;
        repeat (TICK_DIV - 1) @(negedge clk);
        fire_tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        check(int_rst, 1'b1, "R1 rst during hold");
        check(busy, 1'b0, "R1 busy during hold");
        repeat (3) @(negedge clk);
        pwr_on_hold = 1'b0;
        @(negedge clk);
        check(int_rst, 1'b0, "R1 rst after hold release");

        for (int i = 0; i < NROWS; i++) begin
            period(VEC[i][2]);
            check(int_rst, VEC[i][1], $sformatf("R4 int_rst row %0d", i));
            check(busy, VEC[i][0], $sformatf("R6 busy row %0d", i));
        end
        period(1'b0); // back to idle

        // R8: short burst between ticks in idle
        repeat (2) @(negedge clk);
        ext_rst_pin = 1'b1;
        repeat (3) @(negedge clk);
        ext_rst_pin = 1'b0;
        repeat (TICK_DIV - 6) @(negedge clk);
        fire_tick();
        period(1'b1);
        check(int_rst, 1'b0, "R8 burst between ticks ignored");
        period(1'b0);

        // R7: rise driven in the tick cycle is not seen at that tick
        ext_rst_pin = 1'b0;
        repeat (TICK_DIV - 1) @(negedge clk);
        ext_rst_pin = 1'b1;
        fire_tick();
        check(int_rst, 1'b0, "R7 late rise tick 1");
        period(1'b1);
        check(int_rst, 1'b0, "R7 late rise tick 2");
        period(1'b1);
        check(int_rst, 1'b1, "R7 late rise tick 3");

        // R9: hold during pulse aborts, then idle
        period(1'b1);
        pwr_on_hold = 1'b1;
        #1;
        check(int_rst, 1'b1, "R9 rst under hold");
        check(busy, 1'b0, "R9 busy under hold");
        @(negedge clk);
        pwr_on_hold = 1'b0;
        @(negedge clk);
        check(int_rst, 1'b0, "R9 rst after abort");
        period(1'b1);
        check(int_rst, 1'b0, "R9 needs fresh qualify");
        period(1'b1);
        check(int_rst, 1'b1, "R9 new pulse after qualify");
        check(busy, 1'b1, "R6 busy on new pulse");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule